// File: doc/BRIEF.md
# Power-Management Bus Command Channel

This block is one register-mapped command channel in front of a power-management bus engine. Software first loads up to eight payload bytes into two 32-bit write-data registers, then writes a command word. The command write starts the transaction: the channel decodes the operation code, target slave number, 16-bit register address and byte count from the word. It then issues a single-cycle parallel request to a downstream engine, which drives the serial bus itself.

When the engine answers, the channel records the outcome in a status register as a done flag plus at most one error flag. For read operations it also stores the returned bytes in two read-data registers. A command written while a transaction is in flight is discarded, and the in-flight transaction then completes as dropped. A command with an undefined operation code completes at once with a failure and never reaches the engine.

The sequencer has three states. `S_IDLE` moves to `S_ISSUE` when a command with a defined code is written, and stays in `S_IDLE` for an undefined code. `S_ISSUE` always moves to `S_WAIT` on the next cycle. `S_WAIT` returns to `S_IDLE` on the cycle the engine's response is taken.

Top module: `pmic_cmd_channel`

## Requirements
- R1: After reset, every register in the window reads zero and `req_valid` is low.
- R2: The window base is ARRAY_BASE + 0x80 × CHAN_IDX, with CHAN_IDX from 0 to 5. The offsets are: command 0x00, status 0x08, write-data word 0 at 0x10, write-data word 1 at 0x14, read-data word 0 at 0x18 and read-data word 1 at 0x1C. The write-data words read back what was written. Offset 0x04 and all unused offsets read zero. Writes outside the window change nothing and start nothing.
- R3: The command word holds the operation code in [31:27], the slave number in [23:20], the address in [19:4] and the byte count minus one in [2:0]. The other bits read back as zero. An accepted command drives `req_valid` high for exactly one cycle, the cycle after the write, and the request carries these fields.
- R4: For the write-type codes 0, 2, 9, 14 and 16, `req_wdata` is {word1, word0}, with byte k in bits [8k+7:8k]. Bytes above the byte count are zero. For all other codes, `req_wdata` is zero.
- R5: For the bus-control codes 3, 4, 5 and 6, `req_addr` and `req_bcnt` are zero.
- R6: Accepting a command clears the status register. Status then reads zero until the transaction completes.
- R7: A response taken in `S_WAIT` makes status read done (bit 0) on the next cycle. Response code 1 adds failure (bit 1), code 2 adds denied (bit 2), code 3 adds dropped (bit 3), and code 0 adds no error bit.
- R8: For the read-type codes 1, 8, 13 and 15, the response bytes are stored in the read-data words: bytes 0–3 in word 0 and bytes 4–7 in word 1. Bytes above the byte count are stored as zero. For all other codes, the read-data words are unchanged.
- R9: A command written in `S_ISSUE` or `S_WAIT` issues no request and leaves the command register unchanged. The pending transaction then completes with status done plus dropped (0x9), whatever code the response carries.
- R10: A command whose code is 10, 11, 12 or 17 to 31 issues no request and leaves the read-data words unchanged. Status reads 0x3 (done plus failure) on the next cycle.
- R11: `rsp_valid` in `S_IDLE` or `S_ISSUE` is ignored: status and read data keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_valid | output | 1 | One-cycle request to the bus engine |
| req_opcode | output | 5 | Operation code |
| req_sid | output | 4 | Slave number |
| req_addr | output | 16 | Register address on the slave |
| req_bcnt | output | 3 | Byte count minus one |
| req_wdata | output | 64 | Write payload, byte 0 in the low bits |
| rsp_valid | input | 1 | Response from the bus engine |
| rsp_code | input | 2 | 0 ok, 1 fail, 2 deny, 3 drop |
| rsp_rdata | input | 64 | Read bytes returned by the engine |

## Verification
The hardest situations to reach are the late commands of R9. In these, a second command write lands exactly in the single `S_ISSUE` cycle or in `S_WAIT`, and the response must then be rewritten to dropped. The bench produces these cases by writing the second command at chosen clock cycles after the first: once in the issue cycle, followed by a deny response, and once in the wait state, followed by an ok response. It also presents responses in the idle and issue cycles to show that they are ignored. All 32 operation codes and every byte count are swept, and the expected fields, masks and status words are computed arithmetically.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
    localparam int PAY_BYTES = 8;
    localparam int PAY_W     = PAY_BYTES * 8;
    localparam int WORD_W    = 32;
    localparam int NWORDS    = PAY_W / WORD_W;
    localparam int OPC_W     = 5;
    localparam int SID_W     = 4;
    localparam int RADDR_W   = 16;
    localparam int BCNT_W    = 3;
    localparam int OFS_W     = 7;
    localparam int STAT_W    = 4;

    localparam logic [OFS_W-1:0] OFS_CMD  = 7'h00;
    localparam logic [OFS_W-1:0] OFS_STAT = 7'h08;
    localparam logic [OFS_W-1:0] OFS_WD0  = 7'h10;
    localparam logic [OFS_W-1:0] OFS_RD0  = 7'h18;

    localparam int ST_DONE = 0;
    localparam int ST_FAIL = 1;
    localparam int ST_DENY = 2;
    localparam int ST_DROP = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_XWR_LONG  = 5'd0,
        OP_XRD_LONG  = 5'd1,
        OP_XWR       = 5'd2,
        OP_BUS_RESET = 5'd3,
        OP_BUS_SLEEP = 5'd4,
        OP_BUS_OFF   = 5'd5,
        OP_BUS_WAKE  = 5'd6,
        OP_AUTH      = 5'd7,
        OP_MST_RD    = 5'd8,
        OP_MST_WR    = 5'd9,
        OP_XRD       = 5'd13,
        OP_WR        = 5'd14,
        OP_RD        = 5'd15,
        OP_ZWR       = 5'd16
    } opc_e;

    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_FAIL = 2'd1,
        RSP_DENY = 2'd2,
        RSP_DROP = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } seq_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [SID_W-1:0]   sid;
        logic [RADDR_W-1:0] addr;
        logic [BCNT_W-1:0]  bcnt;
    } cmd_t;

    function automatic logic opc_defined(input logic [OPC_W-1:0] o);
        return (o <= OP_MST_WR) || ((o >= OP_XRD) && (o <= OP_ZWR));
    endfunction

    function automatic logic opc_is_read(input logic [OPC_W-1:0] o);
        return (o == OP_XRD_LONG) || (o == OP_MST_RD) || (o == OP_XRD) || (o == OP_RD);
    endfunction

    function automatic logic opc_is_write(input logic [OPC_W-1:0] o);
        return (o == OP_XWR_LONG) || (o == OP_XWR) || (o == OP_MST_WR) ||
               (o == OP_WR) || (o == OP_ZWR);
    endfunction

    function automatic logic opc_is_nodata(input logic [OPC_W-1:0] o);
        return (o >= OP_BUS_RESET) && (o <= OP_BUS_WAKE);
    endfunction

    function automatic logic [PAY_W-1:0] byte_mask(input logic [BCNT_W-1:0] bc);
        logic [PAY_W-1:0] m;
        for (int i = 0; i < PAY_BYTES; i++) begin
            m[i*8 +: 8] = (i <= int'(bc)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction
endpackage

// File: rtl/pcc_regfile.sv
`timescale 1ns/1ps
module pcc_regfile
    import pcc_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cmd_open,
    input  logic [STAT_W-1:0] status,
    input  logic [PAY_W-1:0]  rdata_q,
    output logic [WORD_W-1:0] rd_out,
    output cmd_t              cmd_q,
    output logic [PAY_W-1:0]  wpay,
    output logic              cmd_hit
);
    logic             in_win;
    logic [OFS_W-1:0] off;

    assign in_win  = (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
    assign off     = addr[OFS_W-1:0];
    assign cmd_hit = wr_en && in_win && (off == OFS_CMD);

    // Command register: only updated when the sequencer is idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_hit && cmd_open) begin
            cmd_q.opc  <= wdata[31:27];
            cmd_q.sid  <= wdata[23:20];
            cmd_q.addr <= wdata[19:4];
            cmd_q.bcnt <= wdata[2:0];
        end
    end

    // Write-data words
    for (genvar w = 0; w < NWORDS; w++) begin : g_wd
        localparam logic [OFS_W-1:0] WOFS = OFS_WD0 + OFS_W'(4 * w);
        logic [WORD_W-1:0] wd_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wd_q <= '0;
            end else if (wr_en && in_win && (off == WOFS)) begin
                wd_q <= wdata;
            end
        end
        assign wpay[w*WORD_W +: WORD_W] = wd_q;
    end

    // Read multiplexer
    always_comb begin
        rd_out = '0;
        if (in_win) begin
            if (off == OFS_CMD) begin
                rd_out = {cmd_q.opc, 3'b000, cmd_q.sid, cmd_q.addr, 1'b0, cmd_q.bcnt};
            end
            if (off == OFS_STAT) begin
                rd_out = {{(WORD_W-STAT_W){1'b0}}, status};
            end
            for (int w = 0; w < NWORDS; w++) begin
                if (off == OFS_WD0 + OFS_W'(4 * w)) begin
                    rd_out = wpay[w*WORD_W +: WORD_W];
                end
                if (off == OFS_RD0 + OFS_W'(4 * w)) begin
                    rd_out = rdata_q[w*WORD_W +: WORD_W];
                end
            end
        end
    end
endmodule

// File: rtl/pcc_decode.sv
`timescale 1ns/1ps
module pcc_decode
    import pcc_pkg::*;
(
    input  cmd_t               cmd,
    input  logic [PAY_W-1:0]   wpay,
    output logic [OPC_W-1:0]   req_opcode,
    output logic [SID_W-1:0]   req_sid,
    output logic [RADDR_W-1:0] req_addr,
    output logic [BCNT_W-1:0]  req_bcnt,
    output logic [PAY_W-1:0]   req_wdata,
    output logic               is_read,
    output logic [PAY_W-1:0]   bmask
);
    logic nodata;

    assign nodata     = opc_is_nodata(cmd.opc);
    assign is_read    = opc_is_read(cmd.opc);
    assign bmask      = byte_mask(cmd.bcnt);
    assign req_opcode = cmd.opc;
    assign req_sid    = cmd.sid;
    assign req_addr   = nodata ? '0 : cmd.addr;
    assign req_bcnt   = nodata ? '0 : cmd.bcnt;
    assign req_wdata  = opc_is_write(cmd.opc) ? (wpay & bmask) : '0;
endmodule

// File: rtl/pcc_seq.sv
`timescale 1ns/1ps
module pcc_seq
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_hit,
    input  logic              launch_ok,
    input  logic              is_read,
    input  logic [PAY_W-1:0]  bmask,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_code,
    input  logic [PAY_W-1:0]  rsp_rdata,
    output logic              cmd_open,
    output logic              req_valid,
    output logic              busy,
    output logic [STAT_W-1:0] status,
    output logic [PAY_W-1:0]  rdata_q
);
    seq_e              st_q, st_d;
    logic              drop_q;
    logic              rsp_take;
    logic              late_cmd;
    logic [STAT_W-1:0] done_word;

    assign rsp_take = (st_q == S_WAIT) && rsp_valid;
    assign late_cmd = cmd_hit && (st_q != S_IDLE);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (cmd_hit && launch_ok) st_d = S_ISSUE;
            S_ISSUE: st_d = S_WAIT;
            S_WAIT:  if (rsp_valid) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Completion word
    always_comb begin
        done_word          = '0;
        done_word[ST_DONE] = 1'b1;
        if (drop_q || late_cmd) begin
            done_word[ST_DROP] = 1'b1;
        end else begin
            unique case (rsp_e'(rsp_code))
                RSP_OK:   ;
                RSP_FAIL: done_word[ST_FAIL] = 1'b1;
                RSP_DENY: done_word[ST_DENY] = 1'b1;
                RSP_DROP: done_word[ST_DROP] = 1'b1;
                default:  ;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status  <= '0;
            drop_q  <= 1'b0;
            rdata_q <= '0;
        end else if ((st_q == S_IDLE) && cmd_hit) begin
            status <= launch_ok ? '0 : STAT_W'((1 << ST_DONE) | (1 << ST_FAIL));
        end else if (rsp_take) begin
            status <= done_word;
            drop_q <= 1'b0;
            if (is_read) rdata_q <= rsp_rdata & bmask;
        end else if (late_cmd) begin
            drop_q <= 1'b1;
        end
    end

    assign req_valid = (st_q == S_ISSUE);
    assign busy      = (st_q != S_IDLE);
    assign cmd_open  = (st_q == S_IDLE);
endmodule

// File: rtl/pmic_cmd_channel.sv
`timescale 1ns/1ps
module pmic_cmd_channel
    import pcc_pkg::*;
#(
    parameter int CHAN_IDX   = 0,
    parameter int ADDR_W     = 12,
    parameter int ARRAY_BASE = 'h800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               req_valid,
    output logic [4:0]         req_opcode,
    output logic [3:0]         req_sid,
    output logic [15:0]        req_addr,
    output logic [2:0]         req_bcnt,
    output logic [63:0]        req_wdata,
    input  logic               rsp_valid,
    input  logic [1:0]         rsp_code,
    input  logic [63:0]        rsp_rdata
);
    localparam int                CHAN_STRIDE = 1 << OFS_W;
    localparam logic [ADDR_W-1:0] WIN_BASE    = ADDR_W'(ARRAY_BASE + CHAN_IDX * CHAN_STRIDE);

    if (CHAN_IDX < 0 || CHAN_IDX > 5) begin : g_bad_chan
        $error("channel index out of range");
    end

    cmd_t              cmd_w;
    logic [PAY_W-1:0]  wpay_w;
    logic [PAY_W-1:0]  rdata_w;
    logic [PAY_W-1:0]  bmask_w;
    logic [STAT_W-1:0] status_w;
    logic              cmd_hit_w;
    logic              cmd_open_w;
    logic              launch_ok_w;
    logic              is_read_w;
    logic              busy_w;

    assign launch_ok_w = opc_defined(reg_wdata[31:27]);

    pcc_regfile #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE)
    ) i_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cmd_open (cmd_open_w),
        .status   (status_w),
        .rdata_q  (rdata_w),
        .rd_out   (reg_rdata),
        .cmd_q    (cmd_w),
        .wpay     (wpay_w),
        .cmd_hit  (cmd_hit_w)
    );

    pcc_decode i_decode (
        .cmd        (cmd_w),
        .wpay       (wpay_w),
        .req_opcode (req_opcode),
        .req_sid    (req_sid),
        .req_addr   (req_addr),
        .req_bcnt   (req_bcnt),
        .req_wdata  (req_wdata),
        .is_read    (is_read_w),
        .bmask      (bmask_w)
    );

    pcc_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_hit   (cmd_hit_w),
        .launch_ok (launch_ok_w),
        .is_read   (is_read_w),
        .bmask     (bmask_w),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .rsp_rdata (rsp_rdata),
        .cmd_open  (cmd_open_w),
        .req_valid (req_valid),
        .busy      (busy_w),
        .status    (status_w),
        .rdata_q   (rdata_w)
    );
endmodule

// File: rtl/pcc_checker.sv
`timescale 1ns/1ps
module pcc_checker
    import pcc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [4:0]  req_opcode,
    input logic [15:0] req_addr,
    input logic [2:0]  req_bcnt,
    input logic [63:0] req_wdata,
    input logic [3:0]  status,
    input logic        busy,
    input logic        rsp_valid,
    input logic        cmd_hit,
    input logic        cmd_open,
    input logic        launch_ok
);
    logic [63:0] above_cnt;
    assign above_cnt = req_wdata & ~byte_mask(req_bcnt);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R3
    AST_ACCEPT_THEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd_open && launch_ok) |=> (req_valid && status == 4'h0)); // R6
    AST_BAD_OPC_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd_open && !launch_ok) |=> (!req_valid && status == 4'h3)); // R10
    AST_NODATA_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode >= 5'd3 && req_opcode <= 5'd6) |-> (req_addr == '0 && req_bcnt == '0)); // R5
    AST_PAYLOAD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (above_cnt == '0)); // R4
    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> ($countones(status[3:1]) <= 1)); // R7
    AST_PENDING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status == 4'h0)); // R6
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_valid && rsp_valid) |=> (status[0] && !busy)); // R7
    AST_LATE_CMD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_hit) |=> !req_valid); // R9
endmodule

bind pmic_cmd_channel pcc_checker i_pcc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_opcode (req_opcode),
    .req_addr   (req_addr),
    .req_bcnt   (req_bcnt),
    .req_wdata  (req_wdata),
    .status     (status_w),
    .busy       (busy_w),
    .rsp_valid  (rsp_valid),
    .cmd_hit    (cmd_hit_w),
    .cmd_open   (cmd_open_w),
    .launch_ok  (launch_ok_w)
);

// File: tb/test_pmic_cmd_channel.sv
`timescale 1ns/1ps
module test_pmic_cmd_channel;
    localparam logic [11:0] BASE   = 12'h900;
    localparam logic [11:0] A_CMD  = BASE + 12'h00;
    localparam logic [11:0] A_CFG  = BASE + 12'h04;
    localparam logic [11:0] A_STAT = BASE + 12'h08;
    localparam logic [11:0] A_WD0  = BASE + 12'h10;
    localparam logic [11:0] A_WD1  = BASE + 12'h14;
    localparam logic [11:0] A_RD0  = BASE + 12'h18;
    localparam logic [11:0] A_RD1  = BASE + 12'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [4:0]  req_opcode;
    logic [3:0]  req_sid;
    logic [15:0] req_addr;
    logic [2:0]  req_bcnt;
    logic [63:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_code = '0;
    logic [63:0] rsp_rdata = '0;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        finished = 1'b0;
    logic [63:0] rd_model = '0;

    always #4 clk = ~clk;

    pmic_cmd_channel #(.CHAN_IDX(2)) i_pmic_cmd_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_opcode(req_opcode), .req_sid(req_sid), .req_addr(req_addr),
        .req_bcnt(req_bcnt), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
    );

    function automatic bit m_defined(input int o);
        return (o <= 9) || (o >= 13 && o <= 16);
    endfunction
    function automatic bit m_read(input int o);
        return o == 1 || o == 8 || o == 13 || o == 15;
    endfunction
    function automatic bit m_write(input int o);
        return o == 0 || o == 2 || o == 9 || o == 14 || o == 16;
    endfunction
    function automatic bit m_nodata(input int o);
        return o >= 3 && o <= 6;
    endfunction
    function automatic logic [63:0] m_mask(input int bc);
        return (64'd1 << (8 * (bc + 1))) - 64'd1;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_cmd(input int o, input int s, input int a, input int bc,
                           input logic [31:0] w0, input logic [31:0] w1,
                           input int code, input logic [63:0] rdat);
        logic [31:0] word, back, got;
        logic [63:0] exp_wd;
        logic [3:0]  exp_st;
        string       ftag;
        bus_wr(A_WD0, w0);
        bus_wr(A_WD1, w1);
        word = {5'(o), 3'b111, 4'(s), 16'(a), 1'b1, 3'(bc)};
        back = {5'(o), 3'b000, 4'(s), 16'(a), 1'b0, 3'(bc)};
        bus_wr(A_CMD, word);
        if (!m_defined(o)) begin
            check("R10", "no request for undefined code", req_valid, 1'b0);
            bus_rd(A_STAT, got);
            check("R10", "status after undefined code", got, 64'h3);
            bus_rd(A_RD0, got);
            check("R10", "rd0 kept", got, rd_model[31:0]);
            bus_rd(A_RD1, got);
            check("R10", "rd1 kept", got, rd_model[63:32]);
            return;
        end
        ftag = m_nodata(o) ? "R5" : "R3";
        check("R3", "req_valid after command", req_valid, 1'b1);
        check("R3", "opcode", req_opcode, 64'(o));
        check("R3", "slave", req_sid, 64'(s));
        check(ftag, "address field", req_addr, m_nodata(o) ? 64'h0 : 64'(a));
        check(ftag, "count field", req_bcnt, m_nodata(o) ? 64'h0 : 64'(bc));
        exp_wd = m_write(o) ? ({w1, w0} & m_mask(bc)) : 64'h0;
        check("R4", "payload", req_wdata, exp_wd);
        bus_rd(A_CMD, got);
        check("R3", "command readback", got, back);
        bus_rd(A_STAT, got);
        check("R6", "status cleared while pending", got, 64'h0);
        @(negedge clk);
        check("R3", "request lasts one cycle", req_valid, 1'b0);
        rsp_valid = 1'b1;
        rsp_code  = 2'(code);
        rsp_rdata = rdat;
        @(negedge clk);
        rsp_valid = 1'b0;
        exp_st = 4'h1 | ((code != 0) ? 4'(1 << code) : 4'h0);
        bus_rd(A_STAT, got);
        check("R7", "completion status", got, exp_st);
        if (m_read(o)) rd_model = rdat & m_mask(bc);
        bus_rd(A_RD0, got);
        check("R8", "rd0", got, rd_model[31:0]);
        bus_rd(A_RD1, got);
        check("R8", "rd1", got, rd_model[63:32]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: actual=hung expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [3:0]  st0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "req_valid after reset", req_valid, 1'b0);
        for (int k = 0; k < 8; k++) begin
            bus_rd(BASE + 12'(4 * k) + ((k >= 3) ? 12'h4 : 12'h0), got);
            check("R1", "register zero after reset", got, 64'h0);
        end
        @(negedge clk);

        // R2: window decode
        bus_wr(12'h810, 32'hDEAD0001);
        bus_rd(A_WD0, got);
        check("R2", "foreign write ignored", got, 64'h0);
        bus_rd(12'h810, got);
        check("R2", "foreign window reads zero", got, 64'h0);
        @(negedge clk);
        bus_wr(A_WD1, 32'hCAFE5A5A);
        bus_rd(A_WD1, got);
        check("R2", "wd1 readback", got, 64'hCAFE5A5A);
        bus_rd(A_CFG, got);
        check("R2", "config offset reads zero", got, 64'h0);
        @(negedge clk);
        bus_wr(12'h800, {5'd14, 27'h0000123});
        check("R2", "foreign command starts nothing", req_valid, 1'b0);
        bus_rd(A_STAT, got);
        check("R2", "status untouched by foreign command", got, 64'h0);
        @(negedge clk);

        // Sweep every opcode (R3..R8, R10)
        for (int o = 0; o < 32; o++) begin
            run_cmd(o, o % 16, 'h1000 + o * 'h111, o % 8,
                    32'h03020100 + 32'(o) * 32'h04040404, 32'h07060504 ^ 32'(o),
                    o % 4, {32'hF7F6F5F4 + 32'(o), 32'hF3F2F1F0 - 32'(o)});
            @(negedge clk);
        end
        // Byte-count sweeps for one read and one write code (R4, R8)
        for (int bc = 0; bc < 8; bc++) begin
            run_cmd(15, 3, 'h0A50 + bc, bc, 32'h11223344, 32'h55667788, 0,
                    64'h8877665544332211 ^ 64'(bc));
            @(negedge clk);
            run_cmd(14, 9, 'hBEE0 + bc, bc, 32'hA1B2C3D4, 32'hE5F60718, 0, 64'h0);
            @(negedge clk);
        end

        // R11: response while idle is ignored
        bus_rd(A_STAT, got);
        st0 = got[3:0];
        rsp_valid = 1'b1; rsp_code = 2'd1; rsp_rdata = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        rsp_valid = 1'b0;
        bus_rd(A_STAT, got);
        check("R11", "idle response leaves status", got, 64'(st0));
        bus_rd(A_RD0, got);
        check("R11", "idle response leaves rd0", got, rd_model[31:0]);
        @(negedge clk);

        // R11: response during the issue cycle is ignored
        bus_wr(A_CMD, {5'd15, 3'b0, 4'd2, 16'h0042, 1'b0, 3'd1});
        rsp_valid = 1'b1; rsp_code = 2'd1; rsp_rdata = 64'h1;
        @(negedge clk);
        rsp_valid = 1'b0;
        bus_rd(A_STAT, got);
        check("R11", "issue-cycle response ignored", got, 64'h0);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_code = 2'd0; rsp_rdata = 64'h0000_0000_0000_BEEF;
        @(negedge clk);
        rsp_valid = 1'b0;
        rd_model = 64'hBEEF;
        bus_rd(A_STAT, got);
        check("R11", "later response taken", got, 64'h1);
        bus_rd(A_RD0, got);
        check("R8", "rd0 after issue-cycle test", got, 64'hBEEF);
        @(negedge clk);

        // R9: second command in the wait state
        bus_wr(A_WD0, 32'h0000_00AA);
        bus_wr(A_CMD, {5'd14, 3'b0, 4'd5, 16'h0100, 1'b0, 3'd0});
        check("R9", "first command issued", req_valid, 1'b1);
        @(negedge clk);
        bus_wr(A_CMD, {5'd15, 3'b0, 4'd6, 16'h0200, 1'b0, 3'd3});
        check("R9", "late command issues nothing", req_valid, 1'b0);
        bus_rd(A_CMD, got);
        check("R9", "command register kept", got, {5'd14, 3'b0, 4'd5, 16'h0100, 1'b0, 3'd0});
        rsp_valid = 1'b1; rsp_code = 2'd0;
        @(negedge clk);
        rsp_valid = 1'b0;
        bus_rd(A_STAT, got);
        check("R9", "dropped after wait-state command", got, 64'h9);
        @(negedge clk);
        check("R9", "no request after drop", req_valid, 1'b0);

        // R9: second command in the issue cycle, deny response, read data kept
        bus_wr(A_CMD, {5'd13, 3'b0, 4'd7, 16'h0300, 1'b0, 3'd5});
        bus_wr(A_CMD, {5'd2, 3'b0, 4'd1, 16'h0400, 1'b0, 3'd0});
        check("R9", "issue-cycle command issues nothing", req_valid, 1'b0);
        rsp_valid = 1'b1; rsp_code = 2'd2; rsp_rdata = 64'h0102030405060708;
        @(negedge clk);
        rsp_valid = 1'b0;
        bus_rd(A_STAT, got);
        check("R9", "dropped overrides deny", got, 64'h9);
        rd_model = 64'h0102030405060708 & m_mask(5);
        bus_rd(A_RD1, got);
        check("R8", "rd1 after dropped read", got, rd_model[63:32]);
        @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule